// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads one entry from a page directory and then one entry from a page table, both held in memory. The linear address splits into three fields. The top ten bits pick a directory entry, the next ten bits pick a table entry, and the low twelve bits give the byte offset inside a 4 KB page. The directory always starts on a page boundary. Its base is the upper twenty bits of a root register input, and the walker forces the low twelve bits to zero.

A requester offers a linear address with a valid/ready handshake. The walker then issues its entry reads on a simple memory read port, with one read outstanding at a time. Bit 0 of every entry is a present flag. If that flag is clear at either level, the walk stops and the walker reports a page fault together with the level that faulted. When the translation-enable input is low at acceptance, the walker reads no memory and returns the linear address unchanged.

The result appears as a one-cycle pulse on the response port. The pulse carries the physical address, a fault flag, the fault level and the linear address that was translated.

Top module: `pgw_top`

## Requirements
- R1: The first read of a walk goes to byte address {root_reg[31:12], lin[31:22], 2'b00}, and root_reg[11:0] has no effect on it.
- R2: The second read goes to byte address {D[31:12], lin[21:12], 2'b00}, where D is the directory entry returned by the first read.
- R3: When both entries have bit 0 set, the response carries rsp_fault=0 and rsp_paddr={T[31:12], lin[11:0]}, where T is the table entry. The bits T[11:1] have no effect.
- R4: When the directory entry has bit 0 clear, the walk issues no second read and responds with rsp_fault=1, rsp_fault_lvl=0 and rsp_lin equal to the request address.
- R5: When the table entry has bit 0 clear, the walker responds with rsp_fault=1, rsp_fault_lvl=1 and rsp_lin equal to the request address.
- R6: When xlat_en is low in the accepting cycle, the walker issues no memory read. rsp_valid rises in the cycle after acceptance, with rsp_paddr equal to the linear address and rsp_fault=0.
- R7: mem_req stays high with a stable mem_addr until mem_rvalid is seen. req_ready is low from acceptance until the response has been given. rsp_valid lasts exactly one cycle.
- R8: After reset, req_ready=1, mem_req=0 and rsp_valid=0.
- R9: For a request that does a walk, rsp_valid rises in the cycle right after the cycle in which the last entry read returned its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_en | input | 1 | Translation enable, sampled when a request is accepted |
| root_reg | input | 32 | Root register; bits [31:12] are the directory frame |
| req_valid | input | 1 | Request offered |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle and able to accept |
| mem_req | output | 1 | Entry read pending |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 32 | Entry value returned by memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Page fault flag |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_lin | output | 32 | Linear address of the request being answered |

## Verification
A bypassed request answers in the cycle after the accepting edge. A walked request answers in the cycle after the edge that took the last read's data. The bench therefore stamps each accept and each data delivery with a cycle count taken at the rising edge, and it requires that the response count be exactly one greater. The memory model holds each read for a random 0 to 2 cycles and logs every address it serves. The bench compares that log against the one or two addresses the reference walk predicts. All sampling and driving happens at the falling edge, so a response is always observed in the cycle it becomes visible.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DIR  = 2'd1,
    WS_TBL  = 2'd2,
    WS_RSP  = 2'd3
  } walk_st_e;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_TBL = 1'b1;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     xlat_en,
  input  logic     mem_rvalid,
  input  logic     entry_present,
  output walk_st_e state,
  output logic     ev_accept,
  output logic     ev_dir_ok,
  output logic     ev_dir_miss,
  output logic     ev_tbl_ok,
  output logic     ev_tbl_miss,
  output logic     req_ready,
  output logic     mem_req,
  output logic     rsp_valid
);

  walk_st_e state_q, state_d;

  assign state     = state_q;
  assign req_ready = (state_q == WS_IDLE);
  assign mem_req   = (state_q == WS_DIR) || (state_q == WS_TBL);
  assign rsp_valid = (state_q == WS_RSP);

  // named internal events, used by the datapath and by the assertions
  assign ev_accept   = req_ready && req_valid;
  assign ev_dir_ok   = (state_q == WS_DIR) && mem_rvalid && entry_present;
  assign ev_dir_miss = (state_q == WS_DIR) && mem_rvalid && !entry_present;
  assign ev_tbl_ok   = (state_q == WS_TBL) && mem_rvalid && entry_present;
  assign ev_tbl_miss = (state_q == WS_TBL) && mem_rvalid && !entry_present;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: if (ev_accept) state_d = xlat_en ? WS_DIR : WS_RSP;
      WS_DIR:  if (ev_dir_ok) state_d = WS_TBL;
               else if (ev_dir_miss) state_d = WS_RSP;
      WS_TBL:  if (mem_rvalid) state_d = WS_RSP;
      WS_RSP:  state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  // R7: a pending read is held until data returns
  p_read_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req);

  // R7: no new request is taken while a walk or response is in flight
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

endmodule

// File: rtl/pgw_dpath.sv
module pgw_dpath #(
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_accept,
  input  logic                ev_dir_ok,
  input  logic                ev_dir_miss,
  input  logic                ev_tbl_ok,
  input  logic                ev_tbl_miss,
  input  logic                in_tbl,
  input  logic                mem_pending,
  input  logic                mem_rvalid,
  input  logic                xlat_en,
  input  logic [OFF_W+2*(OFF_W-ENT_LG)-1:OFF_W] root_frame,
  input  logic [OFF_W+2*(OFF_W-ENT_LG)-1:0]     req_lin,
  input  logic [OFF_W+2*(OFF_W-ENT_LG)-1:OFF_W] rd_frame,
  output logic [OFF_W+2*(OFF_W-ENT_LG)-1:0]     mem_addr,
  output logic [OFF_W+2*(OFF_W-ENT_LG)-1:0]     res_paddr,
  output logic                res_fault,
  output logic                res_lvl,
  output logic [OFF_W+2*(OFF_W-ENT_LG)-1:0]     res_lin
);

  import pgw_pkg::*;

  localparam int IDX_W   = OFF_W - ENT_LG;
  localparam int ADDR_W  = OFF_W + 2 * IDX_W;
  localparam int FRAME_W = ADDR_W - OFF_W;

  // address arithmetic kept in functions so the bench can restate it
  function automatic logic [ADDR_W-1:0] dir_entry_addr(
    input logic [FRAME_W-1:0] root, input logic [ADDR_W-1:0] lin);
    return {root, lin[ADDR_W-1 -: IDX_W], {ENT_LG{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_entry_addr(
    input logic [FRAME_W-1:0] tframe, input logic [ADDR_W-1:0] lin);
    return {tframe, lin[OFF_W+IDX_W-1 -: IDX_W], {ENT_LG{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] phys_addr(
    input logic [FRAME_W-1:0] pframe, input logic [ADDR_W-1:0] lin);
    return {pframe, lin[OFF_W-1:0]};
  endfunction

  logic [ADDR_W-1:0]  lin_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] tframe_q;
  logic [ADDR_W-1:0]  paddr_q;
  logic               fault_q;
  logic               lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q    <= '0;
      root_q   <= '0;
      tframe_q <= '0;
      paddr_q  <= '0;
      fault_q  <= 1'b0;
      lvl_q    <= LVL_DIR;
    end else begin
      if (ev_accept) begin
        lin_q   <= req_lin;
        root_q  <= root_frame;
        fault_q <= 1'b0;
        lvl_q   <= LVL_DIR;
        if (!xlat_en) paddr_q <= req_lin;
      end
      if (ev_dir_ok) tframe_q <= rd_frame;
      if (ev_dir_miss) begin
        fault_q <= 1'b1;
        lvl_q   <= LVL_DIR;
        paddr_q <= '0;
      end
      if (ev_tbl_ok) begin
        fault_q <= 1'b0;
        paddr_q <= phys_addr(rd_frame, lin_q);
      end
      if (ev_tbl_miss) begin
        fault_q <= 1'b1;
        lvl_q   <= LVL_TBL;
        paddr_q <= '0;
      end
    end
  end

  assign mem_addr  = in_tbl ? tbl_entry_addr(tframe_q, lin_q)
                            : dir_entry_addr(root_q, lin_q);
  assign res_paddr = paddr_q;
  assign res_fault = fault_q;
  assign res_lvl   = lvl_q;
  assign res_lin   = lin_q;

  // R7: the read address does not move while a read is pending
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pending && !mem_rvalid |=> $stable(mem_addr));

  // R1: the first read of a walk uses the accepted address fields
  p_dir_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && xlat_en |=>
      mem_addr[OFF_W-1:ENT_LG] == $past(req_lin[ADDR_W-1 -: IDX_W]));

endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlat_en,
  input  logic [31:0] root_reg,
  input  logic        req_valid,
  input  logic [31:0] req_lin,
  output logic        req_ready,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_fault_lvl,
  output logic [31:0] rsp_lin
);

  import pgw_pkg::*;

  localparam int IDX_W   = OFF_W - ENT_LG;
  localparam int ADDR_W  = OFF_W + 2 * IDX_W;
  localparam int PRES_B  = 0;

  walk_st_e st;
  logic ev_accept, ev_dir_ok, ev_dir_miss, ev_tbl_ok, ev_tbl_miss;
  logic entry_present;
  logic unused_attr;

  assign entry_present = mem_rdata[PRES_B];
  assign unused_attr   = ^{mem_rdata[OFF_W-1:PRES_B+1], root_reg[OFF_W-1:0]};

  pgw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .xlat_en       (xlat_en),
    .mem_rvalid    (mem_rvalid),
    .entry_present (entry_present),
    .state         (st),
    .ev_accept     (ev_accept),
    .ev_dir_ok     (ev_dir_ok),
    .ev_dir_miss   (ev_dir_miss),
    .ev_tbl_ok     (ev_tbl_ok),
    .ev_tbl_miss   (ev_tbl_miss),
    .req_ready     (req_ready),
    .mem_req       (mem_req),
    .rsp_valid     (rsp_valid)
  );

  pgw_dpath #(.OFF_W(OFF_W), .ENT_LG(ENT_LG)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_accept   (ev_accept),
    .ev_dir_ok   (ev_dir_ok),
    .ev_dir_miss (ev_dir_miss),
    .ev_tbl_ok   (ev_tbl_ok),
    .ev_tbl_miss (ev_tbl_miss),
    .in_tbl      (st == WS_TBL),
    .mem_pending (mem_req),
    .mem_rvalid  (mem_rvalid),
    .xlat_en     (xlat_en),
    .root_frame  (root_reg[ADDR_W-1:OFF_W]),
    .req_lin     (req_lin),
    .rd_frame    (mem_rdata[ADDR_W-1:OFF_W]),
    .mem_addr    (mem_addr),
    .res_paddr   (rsp_paddr),
    .res_fault   (rsp_fault),
    .res_lvl     (rsp_fault_lvl),
    .res_lin     (rsp_lin)
  );

  // R6: bypass answers next cycle with the untouched address
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !xlat_en |=>
      rsp_valid && !rsp_fault && !mem_req && rsp_paddr == $past(req_lin));

  // R2: the table read takes its frame from the directory entry just returned
  p_tbl_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_ok |=> mem_req &&
      mem_addr[ADDR_W-1:OFF_W] == $past(mem_rdata[ADDR_W-1:OFF_W]));

  // R4: a missing directory entry faults at level 0 next cycle
  p_dir_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_miss |=> rsp_valid && rsp_fault && rsp_fault_lvl == LVL_DIR && !mem_req);

  // R5: a missing table entry faults at level 1 next cycle
  p_tbl_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tbl_miss |=> rsp_valid && rsp_fault && rsp_fault_lvl == LVL_TBL);

  // R3 and R9: a good table entry gives the page frame one cycle later
  p_tbl_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tbl_ok |=> rsp_valid && !rsp_fault &&
      rsp_paddr[ADDR_W-1:OFF_W] == $past(mem_rdata[ADDR_W-1:OFF_W]));

  // R7: the response is a single-cycle pulse
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

endmodule

// File: tb/sim_pgw_top.sv
`timescale 1ns/1ps
module sim_pgw_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0;
  logic [31:0] root_reg = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        req_ready, mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_paddr, rsp_lin;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  int unsigned rv_cyc = 0;
  int unsigned wait_cnt = 0;
  bit [31:0] rd_log[$];
  bit [31:0] ovr[bit [31:0]];

  always #2.5 clk = ~clk;

  pgw_top u0 (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .root_reg(root_reg),
    .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl), .rsp_lin(rsp_lin)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // memory contents: explicit overrides, else a hashed word (bit 0 = present)
  function automatic bit [31:0] mem_val(input bit [31:0] a);
    bit [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 13);
    return {h[31:1], (h[6:4] != 3'd0)};
  endfunction

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // memory model: serves one read at a time after 0..2 idle cycles
  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
    end else if (wait_cnt != 0) begin
      wait_cnt   = wait_cnt - 1;
      mem_rvalid = 1'b0;
    end else begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem_val(mem_addr);
      rd_log.push_back(mem_addr);
      rv_cyc     = cyc;
      wait_cnt   = $urandom % 3;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 190000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // translate one address and compare against a walk restated here
  task automatic run_one(input bit [31:0] lin, input bit [31:0] root, input bit en);
    bit [31:0] a0, a1, e0, e1, exp_pa;
    bit exp_fault, exp_lvl;
    int exp_reads;
    int unsigned acc_cyc;
    int n;
    bit seen;
    a0 = {root[31:12], lin[31:22], 2'b00};
    e0 = mem_val(a0);
    a1 = {e0[31:12], lin[21:12], 2'b00};
    e1 = mem_val(a1);
    if (!en) begin exp_reads = 0; exp_fault = 0; exp_lvl = 0; exp_pa = lin; end
    else if (!e0[0]) begin exp_reads = 1; exp_fault = 1; exp_lvl = 0; exp_pa = 0; end
    else if (!e1[0]) begin exp_reads = 2; exp_fault = 1; exp_lvl = 1; exp_pa = 0; end
    else begin exp_reads = 2; exp_fault = 0; exp_lvl = 0; exp_pa = {e1[31:12], lin[11:0]}; end

    @(negedge clk);
    rd_log.delete();
    check(req_ready, "R7", "ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_lin = lin; root_reg = root; xlat_en = en;
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0; req_lin = $urandom; root_reg = $urandom; xlat_en = $urandom;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (rsp_valid) begin seen = 1; break; end
      check(!req_ready, "R7", "ready low while busy", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    if (!seen) begin
      check(0, "R9", "response timeout", 32'd0, 32'd1);
      return;
    end
    n = rd_log.size();
    check(n == exp_reads, en ? (exp_lvl ? "R5" : "R4") : "R6", "read count", n, exp_reads);
    if (n >= 1) check(rd_log[0] == a0, "R1", "directory address", rd_log[0], a0);
    if (n >= 2) check(rd_log[1] == a1, "R2", "table address", rd_log[1], a1);
    if (!en) check(cyc == acc_cyc + 1, "R6", "bypass latency", cyc, acc_cyc + 1);
    else     check(cyc == rv_cyc + 1, "R9", "walk latency", cyc, rv_cyc + 1);
    check(rsp_fault == exp_fault, exp_lvl ? "R5" : "R4", "fault flag", {31'b0, rsp_fault}, {31'b0, exp_fault});
    if (exp_fault) begin
      check(rsp_fault_lvl == exp_lvl, exp_lvl ? "R5" : "R4", "fault level", {31'b0, rsp_fault_lvl}, {31'b0, exp_lvl});
      check(rsp_lin == lin, exp_lvl ? "R5" : "R4", "fault linear address", rsp_lin, lin);
    end else begin
      check(rsp_paddr == exp_pa, en ? "R3" : "R6", "physical address", rsp_paddr, exp_pa);
    end
    @(negedge clk);
    check(!rsp_valid, "R7", "response pulse width", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    bit [31:0] lin, root, d0, t0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(req_ready == 1'b1, "R8", "req_ready at reset", {31'b0, req_ready}, 32'd1);
    check(mem_req == 1'b0, "R8", "mem_req at reset", {31'b0, mem_req}, 32'd0);
    check(rsp_valid == 1'b0, "R8", "rsp_valid at reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: bypass
    run_one(32'hDEAD_BEEF, 32'h1000_0000, 1'b0);

    // R1/R3: root low bits set, table entry carries junk attribute bits
    root = 32'h1234_5ABC; lin = 32'h00C0_3F21;
    d0 = {root[31:12], lin[31:22], 2'b00};
    ovr[d0] = 32'h0ABC_D001;
    t0 = {20'h0ABCD, lin[21:12], 2'b00};
    ovr[t0] = 32'h7777_7FFF;
    run_one(lin, root, 1'b1);
    run_one(lin, 32'h1234_5000, 1'b1);

    // R4: directory entry not present
    lin = 32'h4560_0123; root = 32'h0002_2000;
    ovr[{root[31:12], lin[31:22], 2'b00}] = 32'h1111_1FFE;
    run_one(lin, root, 1'b1);

    // R5: table entry not present
    lin = 32'h8881_2FFF; root = 32'h0003_3000;
    ovr[{root[31:12], lin[31:22], 2'b00}] = 32'h0044_4001;
    ovr[{20'h00444, lin[21:12], 2'b00}] = 32'h9999_9000;
    run_one(lin, root, 1'b1);

    // extremes of the linear address
    run_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_one(32'h0000_0000, 32'h0000_0000, 1'b1);
    run_one(32'h0000_0000, 32'h0000_0000, 1'b0);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      run_one($urandom, $urandom, ($urandom % 5) != 0);
      if (($urandom % 4) == 0) @(negedge clk);
    end
    summary();
  end

endmodule